// File: doc/BRIEF.md
# Rate-Timed Conversion Sequencer with Limit Alarms

This block decides when a temperature measurement cycle starts. In normal running it starts a cycle after a fixed number of ticks from a 16 Hz reference timebase. A 3-bit rate code chooses one of eight rates, each double the one below it, from one cycle per 16 seconds up to eight cycles per second. In standby no periodic cycles start. A write to the trigger address then starts exactly one cycle, and the block goes back to waiting.

Every cycle is a handshake with an external converter. The block raises `conv_start` for one clock. The converter later raises `conv_done` and presents a local result and a remote result. On that completion edge, each result is compared as a signed 8-bit value against its own high and low limits. The four alarm flags are registered at that edge and keep their values until the next completion.

A small register port sets the rate and the four limits and reads them back. The address map is: 0 rate, 1 local high, 2 local low, 3 remote high, 4 remote low, 5 one-shot trigger.

Top module: `conv_sequencer`

## Requirements
- R1: While `rst_n` is low and afterwards, the rate reads 0x07, both high limits read 0x7F, both low limits read 0x80, all alarms are 0 and `conv_start` is 0.
- R2: When not in standby with rate code k (0..7), the first `conv_start` follows the 2^(8-k)-th tick after leaving standby or reset, and one follows every further 2^(8-k) ticks when each conversion completes promptly.
- R3: A write of 0x08..0xFF to address 0 is ignored; the previous rate still reads back and still sets the period.
- R4: Addresses 1 to 4 (local high, local low, remote high, remote low) store the written byte, and it reads back unchanged.
- R5: In standby, a write to address 5 gives exactly one `conv_start` on the clock after the write and no further starts until the next trigger.
- R6: Data written to address 5 is not stored; address 5 reads 0x00 and the other registers are unchanged.
- R7: A write to address 5 while not in standby starts no cycle and leaves periodic timing unchanged.
- R8: In standby, ticks start no cycles.
- R9: A high alarm is 1 only when the signed result is strictly greater than the signed high limit; equality gives 0.
- R10: A low alarm is 1 only when the signed result is strictly less than the signed low limit; equality gives 0.
- R11: Alarm flags change only on the completion edge of a started conversion; a `conv_done` with no conversion pending is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for `reg_addr` (combinational) |
| standby | input | 1 | 1 stops periodic conversions |
| tick | input | 1 | One-clock pulse from the 16 Hz timebase |
| conv_start | output | 1 | One-clock request to start a conversion |
| conv_done | input | 1 | Conversion complete; results valid |
| local_res | input | 8 | Local result, signed |
| remote_res | input | 8 | Remote result, signed |
| alarm_local_hi | output | 1 | Local result above local high limit |
| alarm_local_lo | output | 1 | Local result below local low limit |
| alarm_remote_hi | output | 1 | Remote result above remote high limit |
| alarm_remote_lo | output | 1 | Remote result below remote low limit |

## Verification
The bench runs every rate code and counts ticks to the first and second start. A period off by one tick, or an inverted shift, would move those starts. It sweeps all 256 signed results against limits placed at mixed signs. This catches unsigned compares, which misorder negative values, and non-strict compares, which alarm on equality. It also writes reserved rate codes, fires triggers inside and outside standby, and sends a stray `conv_done`. A design that accepted code 0x08, stored trigger data, started a cycle outside standby or refreshed alarms at the wrong time would show up in read-back, start counts or held flags.

// File: rtl/cseq_pkg.sv
// Shared constants for the conversion sequencer.
// Assumes an 8-bit register port and a 3-bit address space.
package cseq_pkg;
    localparam int DW = 8;
    localparam int AW = 3;
    localparam int RW = 3;
    localparam int SHIFT_MAX = 8;
    localparam int NCH = 2;

    localparam logic [AW-1:0] ADR_RATE    = 3'd0;
    localparam logic [AW-1:0] ADR_LOC_HI  = 3'd1;
    localparam logic [AW-1:0] ADR_LOC_LO  = 3'd2;
    localparam logic [AW-1:0] ADR_REM_HI  = 3'd3;
    localparam logic [AW-1:0] ADR_REM_LO  = 3'd4;
    localparam logic [AW-1:0] ADR_TRIGGER = 3'd5;

    typedef enum logic {S_IDLE, S_BUSY} seq_state_e;
endpackage

// File: rtl/cseq_regs.sv
// Register file: rate code, four limits and the trigger decode.
// Assumes a single-cycle write strobe. Reads are combinational.
// Reserved rate codes are dropped. Trigger data is never stored.
module cseq_regs
    import cseq_pkg::*;
#(
    parameter int P_DW = DW,
    parameter int P_AW = AW,
    parameter int P_RW = RW,
    parameter int P_NCH = NCH
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        wr,
    input  logic [P_AW-1:0]             addr,
    input  logic [P_DW-1:0]             wdata,
    output logic [P_DW-1:0]             rdata,
    output logic [P_RW-1:0]             rate,
    output logic [P_NCH-1:0][P_DW-1:0]  lim_hi,
    output logic [P_NCH-1:0][P_DW-1:0]  lim_lo,
    output logic                        trig_wr
);
    localparam int MAXCODE = (1 << P_RW) - 1;
    localparam logic [P_DW-1:0] HI_RST = {1'b0, {(P_DW-1){1'b1}}};
    localparam logic [P_DW-1:0] LO_RST = {1'b1, {(P_DW-1){1'b0}}};

    logic code_ok;
    assign code_ok = (wdata <= P_DW'(MAXCODE));
    assign trig_wr = wr && (addr == ADR_TRIGGER);

    // Stores writes to the rate and limit registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rate   <= P_RW'(MAXCODE);
            lim_hi <= {P_NCH{HI_RST}};
            lim_lo <= {P_NCH{LO_RST}};
        end else if (wr) begin
            case (addr)
                ADR_RATE:   if (code_ok) rate <= wdata[P_RW-1:0];
                ADR_LOC_HI: lim_hi[0] <= wdata;
                ADR_LOC_LO: lim_lo[0] <= wdata;
                ADR_REM_HI: lim_hi[1] <= wdata;
                ADR_REM_LO: lim_lo[1] <= wdata;
                default: ;
            endcase
        end
    end

    // Selects the read data. The trigger address reads as zero.
    always_comb begin
        case (addr)
            ADR_RATE:   rdata = {{(P_DW-P_RW){1'b0}}, rate};
            ADR_LOC_HI: rdata = lim_hi[0];
            ADR_LOC_LO: rdata = lim_lo[0];
            ADR_REM_HI: rdata = lim_hi[1];
            ADR_REM_LO: rdata = lim_lo[1];
            default:    rdata = '0;
        endcase
    end

    AST_RESERVED_RATE_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && addr == ADR_RATE && !code_ok) |=> $stable(rate)); // R3
    AST_TRIGGER_NOT_STORED: assert property (@(posedge clk) disable iff (!rst_n)
        trig_wr |=> ($stable(rate) && $stable(lim_hi) && $stable(lim_lo))); // R6
endmodule

// File: rtl/cseq_timer.sv
// Rate timer: counts reference ticks and flags when a cycle is due.
// The period is 2^(SHIFT_MAX-rate) ticks. The count is cleared when not running.
// Assumes tick is a one-clock pulse.
module cseq_timer #(
    parameter int P_RW = 3,
    parameter int P_SHIFT_MAX = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            run,
    input  logic            tick,
    input  logic [P_RW-1:0] rate,
    output logic            due
);
    localparam int CW = P_SHIFT_MAX;

    logic [CW-1:0] cnt;
    logic [CW:0]   period_m1;

    // Last tick index of the current period.
    assign period_m1 = ({{CW{1'b0}}, 1'b1} << (P_SHIFT_MAX - int'(rate))) - 1'b1;
    // Uses >= so that a shorter new period takes effect at once.
    assign due = run && tick && ({1'b0, cnt} >= period_m1);

    // Advances on each tick and wraps once a cycle is due.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            cnt <= '0;
        end else if (tick) begin
            cnt <= due ? '0 : cnt + 1'b1;
        end
    end
endmodule

// File: rtl/cseq_limits.sv
// Limit comparator: compares each channel's result with its limits
// as signed values, using strict > and <. Flags load only on upd.
module cseq_limits #(
    parameter int P_DW = 8,
    parameter int P_NCH = 2
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        upd,
    input  logic [P_NCH-1:0][P_DW-1:0]  res,
    input  logic [P_NCH-1:0][P_DW-1:0]  lim_hi,
    input  logic [P_NCH-1:0][P_DW-1:0]  lim_lo,
    output logic [P_NCH-1:0]            flag_hi,
    output logic [P_NCH-1:0]            flag_lo
);
    for (genvar ch = 0; ch < P_NCH; ch++) begin : g_ch
        // Loads this channel's flags when a conversion completes.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                flag_hi[ch] <= 1'b0;
                flag_lo[ch] <= 1'b0;
            end else if (upd) begin
                flag_hi[ch] <= $signed(res[ch]) > $signed(lim_hi[ch]);
                flag_lo[ch] <= $signed(res[ch]) < $signed(lim_lo[ch]);
            end
        end

        AST_HI_EQUAL_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
            (upd && res[ch] == lim_hi[ch]) |=> !flag_hi[ch]); // R9
        AST_LO_EQUAL_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
            (upd && res[ch] == lim_lo[ch]) |=> !flag_lo[ch]); // R10
    end

    AST_FLAGS_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        !upd |=> ($stable(flag_hi) && $stable(flag_lo))); // R11
endmodule

// File: rtl/conv_sequencer.sv
// Top: starts conversion cycles from the rate timer or from a trigger
// write in standby, waits for conv_done, then updates the limit alarms.
// Assumes the converter answers every conv_start with one conv_done.
module conv_sequencer
    import cseq_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          reg_wr,
    input  logic [AW-1:0] reg_addr,
    input  logic [DW-1:0] reg_wdata,
    output logic [DW-1:0] reg_rdata,
    input  logic          standby,
    input  logic          tick,
    output logic          conv_start,
    input  logic          conv_done,
    input  logic [DW-1:0] local_res,
    input  logic [DW-1:0] remote_res,
    output logic          alarm_local_hi,
    output logic          alarm_local_lo,
    output logic          alarm_remote_hi,
    output logic          alarm_remote_lo
);
    logic [RW-1:0]          rate;
    logic [NCH-1:0][DW-1:0] lim_hi, lim_lo, res;
    logic [NCH-1:0]         flag_hi, flag_lo;
    logic                   trig_wr, due, fire_trig, fire_per, upd;
    seq_state_e             state;

    cseq_regs #(.P_DW(DW), .P_AW(AW), .P_RW(RW), .P_NCH(NCH)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr(reg_wr), .addr(reg_addr),
        .wdata(reg_wdata), .rdata(reg_rdata), .rate(rate),
        .lim_hi(lim_hi), .lim_lo(lim_lo), .trig_wr(trig_wr)
    );

    cseq_timer #(.P_RW(RW), .P_SHIFT_MAX(SHIFT_MAX)) u_timer (
        .clk(clk), .rst_n(rst_n), .run(!standby), .tick(tick),
        .rate(rate), .due(due)
    );

    assign res = {remote_res, local_res};

    cseq_limits #(.P_DW(DW), .P_NCH(NCH)) u_limits (
        .clk(clk), .rst_n(rst_n), .upd(upd), .res(res),
        .lim_hi(lim_hi), .lim_lo(lim_lo),
        .flag_hi(flag_hi), .flag_lo(flag_lo)
    );

    assign fire_trig = (state == S_IDLE) && standby && trig_wr;
    assign fire_per  = (state == S_IDLE) && !standby && due;
    assign upd       = (state == S_BUSY) && conv_done;

    // Sequences idle -> busy -> idle and issues the start pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state      <= S_IDLE;
            conv_start <= 1'b0;
        end else begin
            conv_start <= fire_trig || fire_per;
            case (state)
                S_IDLE: if (fire_trig || fire_per) state <= S_BUSY;
                S_BUSY: if (conv_done) state <= S_IDLE;
                default: state <= S_IDLE;
            endcase
        end
    end

    assign alarm_local_hi  = flag_hi[0];
    assign alarm_remote_hi = flag_hi[1];
    assign alarm_local_lo  = flag_lo[0];
    assign alarm_remote_lo = flag_lo[1];

    AST_START_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        conv_start |=> !conv_start); // R5
    AST_TRIGGER_STARTS: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_IDLE && standby && trig_wr) |=> conv_start); // R5
    AST_STANDBY_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_IDLE && standby && !trig_wr) |=> !conv_start); // R8
    AST_RUN_TRIGGER_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_IDLE && !standby && !tick) |=> !conv_start); // R7
endmodule

// File: tb/sim_conv_sequencer.sv
module sim_conv_sequencer;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       reg_wr = 1'b0;
    logic [2:0] reg_addr = '0;
    logic [7:0] reg_wdata = '0;
    logic [7:0] reg_rdata;
    logic       standby = 1'b1;
    logic       tick = 1'b0;
    logic       conv_start;
    logic       conv_done = 1'b0;
    logic [7:0] local_res = '0;
    logic [7:0] remote_res = '0;
    logic       a_lh, a_ll, a_rh, a_rl;
    logic       stray_done = 1'b0;
    int checks = 0;
    int failures = 0;
    int starts = 0;
    bit finished = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    conv_sequencer u0 (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .standby(standby),
        .tick(tick), .conv_start(conv_start), .conv_done(conv_done),
        .local_res(local_res), .remote_res(remote_res),
        .alarm_local_hi(a_lh), .alarm_local_lo(a_ll),
        .alarm_remote_hi(a_rh), .alarm_remote_lo(a_rl)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // One clock: counts starts and answers each with conv_done.
    task automatic step(input bit tk);
        @(negedge clk);
        tick = tk;
        if (conv_start) starts++;
        conv_done = conv_start || stray_done;
        @(posedge clk);
        #1;
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        step(0);
        reg_wr = 1'b0;
    endtask

    task automatic rd_check(input string req, input logic [2:0] a, input int exp);
        reg_addr = a;
        #1;
        check(req, int'(reg_rdata), exp);
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin
            step(1);
            step(0);
        end
    endtask

    task automatic restart_timer();
        standby = 1'b1; step(0); step(0);
        standby = 1'b0; step(0);
    endtask

    task automatic one_shot();
        wr(3'd5, 8'h5A);
        step(0);
        step(0);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        if (!finished) begin
            failures++;
            $display("FAIL watchdog actual=1 expected=0");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        // R1 reset state
        step(0); step(0);
        check("R1 start in reset", int'(conv_start), 0);
        rst_n = 1'b1;
        step(0);
        rd_check("R1 rate", 3'd0, 7);
        rd_check("R1 loc hi", 3'd1, 8'h7F);
        rd_check("R1 loc lo", 3'd2, 8'h80);
        rd_check("R1 rem hi", 3'd3, 8'h7F);
        rd_check("R1 rem lo", 3'd4, 8'h80);
        check("R1 alarms", int'({a_lh, a_ll, a_rh, a_rl}), 0);

        // R4 limit registers
        wr(3'd1, 8'h11); wr(3'd2, 8'hE2); wr(3'd3, 8'h33); wr(3'd4, 8'hC4);
        rd_check("R4 loc hi", 3'd1, 8'h11);
        rd_check("R4 loc lo", 3'd2, 8'hE2);
        rd_check("R4 rem hi", 3'd3, 8'h33);
        rd_check("R4 rem lo", 3'd4, 8'hC4);

        // R8 standby ignores ticks
        starts = 0;
        ticks(40);
        check("R8 no starts in standby", starts, 0);

        // R2 every rate code
        for (int k = 0; k < 8; k++) begin
            int p;
            p = 1 << (8 - k);
            wr(3'd0, 8'(k));
            restart_timer();
            starts = 0;
            ticks(p - 1);
            check($sformatf("R2 code %0d before first", k), starts, 0);
            ticks(1);
            check($sformatf("R2 code %0d first", k), starts, 1);
            ticks(p);
            check($sformatf("R2 code %0d second", k), starts, 2);
        end

        // R3 reserved codes
        wr(3'd0, 8'd3);
        wr(3'd0, 8'h08); wr(3'd0, 8'hFF); wr(3'd0, 8'h80);
        rd_check("R3 rate kept", 3'd0, 3);
        restart_timer();
        starts = 0;
        ticks(31);
        check("R3 period kept before", starts, 0);
        ticks(1);
        check("R3 period kept at 32", starts, 1);

        // R7 trigger outside standby
        wr(3'd0, 8'd7);
        restart_timer();
        starts = 0;
        wr(3'd5, 8'hFF);
        step(0); step(0);
        check("R7 no start from trigger", starts, 0);
        ticks(4);
        check("R7 periodic unchanged", starts, 2);

        // R5 and R6 trigger in standby
        standby = 1'b1; step(0); step(0);
        starts = 0;
        wr(3'd5, 8'hA5);
        step(0);
        check("R5 one start", starts, 1);
        ticks(10);
        check("R5 no extra starts", starts, 1);
        rd_check("R6 trigger reads zero", 3'd5, 0);
        rd_check("R6 rate intact", 3'd0, 7);
        rd_check("R6 loc hi intact", 3'd1, 8'h11);

        // R9 and R10 full signed sweep
        wr(3'd1, 8'd80); wr(3'd2, 8'hFB); wr(3'd3, 8'hEC); wr(3'd4, 8'hD8);
        for (int r = -128; r < 128; r++) begin
            local_res = 8'(r); remote_res = 8'(r);
            one_shot();
            check($sformatf("R9 loc hi r=%0d", r), int'(a_lh), int'(r > 80));
            check($sformatf("R10 loc lo r=%0d", r), int'(a_ll), int'(r < -5));
            check($sformatf("R9 rem hi r=%0d", r), int'(a_rh), int'(r > -20));
            check($sformatf("R10 rem lo r=%0d", r), int'(a_rl), int'(r < -40));
        end

        // R11 hold between conversions and stray done
        local_res = 8'd100; remote_res = 8'h80;
        one_shot();
        check("R11 set loc hi", int'(a_lh), 1);
        check("R11 set rem lo", int'(a_rl), 1);
        local_res = 8'd0; remote_res = 8'd0;
        ticks(5);
        stray_done = 1'b1; step(0); step(0); stray_done = 1'b0;
        step(0);
        check("R11 held loc hi", int'(a_lh), 1);
        check("R11 held rem lo", int'(a_rl), 1);
        one_shot();
        check("R11 refreshed loc hi", int'(a_lh), 0);
        check("R11 refreshed rem lo", int'(a_rl), 0);

        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule